// File: doc/BRIEF.md
# Dual-Lane Bidirectional Serial-to-Parallel Latch Driver

This block is the digital control logic for a 64-channel output driver that is loaded serially. Two 32-stage shift registers run from one clock, so two bits are loaded on every rising edge. Lane 0 serves channels 1 to 32 and lane 1 serves channels 33 to 64. A direction input sets whether the bits move toward higher or lower channel numbers. The same input decides which of each lane's two data pins takes serial data and which drives the cascade bit to the next device in a chain.

Behind the shift path sits a 64-bit latch bank with an active-high latch enable. A low level on the blank input turns every channel on. When blank is high, each channel shows the inverse of its latched bit.

Each lane pin is split into a separate input, output and output-enable signal, so no tristate pad is modelled. Serial data has no valid/ready handshake. The shift path accepts one bit per lane on every clock and cannot apply back-pressure. Every control pin is a plain level.

Top module: `serpar_driver`

## Requirements
- R1: A synchronous reset clears every shift stage and every latch bit. With blank high after reset, all 64 `chan_on` bits are 1 and both cascade outputs of each lane read 0.
- R2: With `dir_fwd`=1, each rising edge loads stage 0 of lane L from `a_in[L]` and moves stage k-1 into stage k.
- R3: With `dir_fwd`=0, each rising edge loads the last stage (31) of lane L from `b_in[L]` and moves stage k+1 into stage k.
- R4: With `dir_fwd`=1, `b_oe[L]`=1 and `a_oe[L]`=0. With `dir_fwd`=0, `a_oe[L]`=1 and `b_oe[L]`=0. The two enables are never high together.
- R5: `b_out[L]` always equals stage 31 of lane L and `a_out[L]` always equals stage 0. So the enabled pin carries the stage that leaves the register in the active direction.
- R6: `lat_en` and `blank_n` have no effect on shifting or on the cascade outputs.
- R7: On a rising edge with `lat_en`=1, the latches take the shift-register contents as they stand after that edge, so the data falls through.
- R8: On a rising edge with `lat_en`=0, the latches keep their value.
- R9: While `blank_n`=0, all 64 `chan_on` bits are 1, whatever the latches hold.
- R10: While `blank_n`=1, `chan_on[j]` is 1 when latch bit j is 0 and 0 when it is 1.
- R11: Stage k of lane 0 maps to `chan_on[k]` (channel k+1). Stage k of lane 1 maps to `chan_on[32+k]` (channel 33+k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and latch clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dir_fwd | input | 1 | 1 = shift toward higher channels, 0 = toward lower |
| lat_en | input | 1 | Latch transparent when high, holding when low |
| blank_n | input | 1 | Active-low blank, forces all channels on |
| a_in | input | 2 | Per-lane A-side pin input (serial data when forward) |
| a_out | output | 2 | Per-lane A-side pin output value (stage 0) |
| a_oe | output | 2 | Per-lane A-side output enable (high when reverse) |
| b_in | input | 2 | Per-lane B-side pin input (serial data when reverse) |
| b_out | output | 2 | Per-lane B-side pin output value (last stage) |
| b_oe | output | 2 | Per-lane B-side output enable (high when forward) |
| chan_on | output | 64 | Channel state, 1 = on, bit j is channel j+1 |

## Verification
The shift and latch properties assume that `rst` is high from time zero through the first edge and that all inputs are at known levels at every rising edge. The bench meets both. It holds reset from the start and changes inputs only on falling edges. The properties do not assume any fixed relation between `lat_en`, `blank_n` and direction, because the block permits any mix. The random phase therefore changes direction, latch enable and blank freely on every cycle, using a fixed seed. Directed single-bit walks cover both ends of each lane and the channel mapping.

// File: rtl/serpar_pkg.sv
package serpar_pkg;
  localparam int unsigned DEF_LANES = 2;
  localparam int unsigned DEF_DEPTH = 32;

  typedef enum logic {
    SHIFT_DOWN = 1'b0,
    SHIFT_UP   = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/serpar_lane.sv
module serpar_lane
  import serpar_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  shift_dir_e       dir,
  input  logic             lo_in,
  input  logic             hi_in,
  output logic [DEPTH-1:0] stg_q,
  output logic [DEPTH-1:0] stg_nxt
);

  always_comb begin
    if (dir == SHIFT_UP) stg_nxt = {stg_q[DEPTH-2:0], lo_in};
    else                 stg_nxt = {hi_in, stg_q[DEPTH-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) stg_q <= '0;
    else     stg_q <= stg_nxt;
  end

  // R2: upward move, entry at stage 0
  a_r2_up_shift: assert property (@(posedge clk) disable iff (rst)
    (dir == SHIFT_UP) |=> (stg_q[0] == $past(lo_in)) &&
                          (stg_q[DEPTH-1:1] == $past(stg_q[DEPTH-2:0])));

  // R3: downward move, entry at last stage
  a_r3_down_shift: assert property (@(posedge clk) disable iff (rst)
    (dir == SHIFT_DOWN) |=> (stg_q[DEPTH-1] == $past(hi_in)) &&
                            (stg_q[DEPTH-2:0] == $past(stg_q[DEPTH-1:1])));

endmodule

// File: rtl/serpar_outstage.sv
module serpar_outstage #(
  parameter int unsigned NCH = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lat_en,
  input  logic           blank_n,
  input  logic [NCH-1:0] src,
  output logic [NCH-1:0] lat_q,
  output logic [NCH-1:0] chan_on
);

  always_ff @(posedge clk) begin
    if (rst)         lat_q <= '0;
    else if (lat_en) lat_q <= src;
  end

  always_comb begin
    if (!blank_n) chan_on = '1;
    else          chan_on = ~lat_q;
  end

  // R8: latches hold while enable is low
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !lat_en |=> $stable(lat_q));

  // R9: blank forces every channel on
  a_r9_blank_all_on: assert property (@(posedge clk) disable iff (rst)
    !blank_n |-> (&chan_on));

endmodule

// File: rtl/serpar_driver.sv
module serpar_driver
  import serpar_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned DEPTH = DEF_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_fwd,
  input  logic             lat_en,
  input  logic             blank_n,
  input  logic [LANES-1:0] a_in,
  output logic [LANES-1:0] a_out,
  output logic [LANES-1:0] a_oe,
  input  logic [LANES-1:0] b_in,
  output logic [LANES-1:0] b_out,
  output logic [LANES-1:0] b_oe,
  output logic [LANES*DEPTH-1:0] chan_on
);

  localparam int unsigned NCH = LANES * DEPTH;

  shift_dir_e     dir;
  logic [NCH-1:0] sr_q;
  logic [NCH-1:0] sr_nxt;
  logic [NCH-1:0] lat_q;

  assign dir = dir_fwd ? SHIFT_UP : SHIFT_DOWN;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    serpar_lane #(.DEPTH(DEPTH)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .dir     (dir),
      .lo_in   (a_in[g]),
      .hi_in   (b_in[g]),
      .stg_q   (sr_q[g*DEPTH +: DEPTH]),
      .stg_nxt (sr_nxt[g*DEPTH +: DEPTH])
    );
    assign a_out[g] = sr_q[g*DEPTH];
    assign b_out[g] = sr_q[g*DEPTH + DEPTH - 1];
    assign a_oe[g]  = (dir == SHIFT_DOWN);
    assign b_oe[g]  = (dir == SHIFT_UP);
  end

  serpar_outstage #(.NCH(NCH)) u_out (
    .clk     (clk),
    .rst     (rst),
    .lat_en  (lat_en),
    .blank_n (blank_n),
    .src     (sr_nxt),
    .lat_q   (lat_q),
    .chan_on (chan_on)
  );

  // R4: only one pin per lane drives
  a_r4_one_driver: assert property (@(posedge clk) disable iff (rst)
    ((a_oe & b_oe) == '0) && ((a_oe | b_oe) == '1));

  // R7: latch equals shift path after a transparent edge
  a_r7_fall_through: assert property (@(posedge clk) disable iff (rst)
    lat_en |=> (lat_q == sr_q));

  // R1: reset clears latches and stages
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (lat_q == '0) && (sr_q == '0));

endmodule

// File: tb/sim_serpar_driver.sv
module sim_serpar_driver;
  localparam int LANES = 2;
  localparam int DEPTH = 32;
  localparam int NCH   = LANES * DEPTH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_fwd = 1'b1;
  logic lat_en = 1'b0;
  logic blank_n = 1'b1;
  logic [LANES-1:0] a_in = '0;
  logic [LANES-1:0] b_in = '0;
  logic [LANES-1:0] a_out, a_oe, b_out, b_oe;
  logic [NCH-1:0] chan_on;

  logic [NCH-1:0] m_sr;
  logic [NCH-1:0] m_lat;
  int checks = 0;
  int fails  = 0;
  int unsigned seed = 32'd1789;

  always #2.5 clk = ~clk;

  serpar_driver #(.LANES(LANES), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .dir_fwd(dir_fwd), .lat_en(lat_en),
    .blank_n(blank_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .chan_on(chan_on)
  );

  function automatic logic [NCH-1:0] shift_model(logic [NCH-1:0] s, logic up,
                                                 logic [LANES-1:0] ai,
                                                 logic [LANES-1:0] bi);
    logic [NCH-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (up) r[l*DEPTH+k] = (k == 0) ? ai[l] : s[l*DEPTH+k-1];
        else    r[l*DEPTH+k] = (k == DEPTH-1) ? bi[l] : s[l*DEPTH+k+1];
      end
    end
    return r;
  endfunction

  function automatic logic [NCH-1:0] exp_chan(logic [NCH-1:0] lat, logic bl_n);
    return bl_n ? ~lat : '1;
  endfunction

  task automatic check(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: inputs already driven; update model at edge, sample at falling edge
  task automatic tick();
    @(posedge clk);
    if (rst) begin
      m_sr = '0; m_lat = '0;
    end else begin
      m_sr = shift_model(m_sr, dir_fwd, a_in, b_in);
      if (lat_en) m_lat = m_sr;
    end
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    check({tag, " R9/R10 chan_on"}, chan_on, exp_chan(m_lat, blank_n));
    check({tag, " R5 cascade"}, {{(NCH-4){1'b0}}, a_out, b_out},
          {{(NCH-4){1'b0}}, m_sr[DEPTH], m_sr[0], m_sr[NCH-1], m_sr[DEPTH-1]});
    check({tag, " R4 roles"}, {{(NCH-4){1'b0}}, a_oe, b_oe},
          {{(NCH-4){1'b0}}, {2{~dir_fwd}}, {2{dir_fwd}}});
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_sr = '0; m_lat = '0;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    // R1: reset state
    check("R1 chan_on after reset", chan_on, '1);
    check("R1 cascade after reset", {{(NCH-4){1'b0}}, a_out, b_out}, '0);

    // R2/R11: walk single 1 on lane 0 forward; ends at channel 32
    dir_fwd = 1'b1;
    for (int c = 0; c < DEPTH; c++) begin
      a_in = (c == 0) ? 2'b01 : 2'b00;
      tick();
    end
    a_in = '0; lat_en = 1'b1; tick(); lat_en = 1'b0;
    // that extra tick moved the bit out; redo: latch directly as bit reaches stage 31
    rst = 1'b1; tick(); rst = 1'b0;
    for (int c = 0; c < DEPTH; c++) begin
      a_in = (c == 0) ? 2'b01 : 2'b00;
      lat_en = (c == DEPTH-1);
      tick();
    end
    lat_en = 1'b0;
    check("R2 R11 R7 forward walk to channel 32", chan_on, ~(64'h1 << 31));
    check("R5 forward cascade lane0", {{(NCH-1){1'b0}}, b_out[0]}, 64'h1);
    blank_n = 1'b0; #1;
    check("R9 blank over walk", chan_on, '1);
    blank_n = 1'b1;

    // R3/R11: walk single 1 on lane 1 reverse; ends at channel 33
    rst = 1'b1; tick(); rst = 1'b0;
    dir_fwd = 1'b0;
    for (int c = 0; c < DEPTH; c++) begin
      b_in = (c == 0) ? 2'b10 : 2'b00;
      lat_en = (c == DEPTH-1);
      tick();
    end
    lat_en = 1'b0;
    check("R3 R11 R7 reverse walk to channel 33", chan_on, ~(64'h1 << 32));
    check("R5 reverse cascade lane1", {{(NCH-1){1'b0}}, a_out[1]}, 64'h1);

    // R8: latches hold while shifting continues
    for (int c = 0; c < 5; c++) begin
      b_in = 2'b11; tick();
    end
    check("R8 hold while lat_en low", chan_on, ~(64'h1 << 32));

    // 32 clocks known random pattern each direction, then latch pulse
    for (int d = 0; d < 2; d++) begin
      dir_fwd = (d == 0);
      for (int c = 0; c < DEPTH; c++) begin
        a_in = 2'($urandom(seed)); seed = seed + 1;
        b_in = 2'($urandom(seed)); seed = seed + 1;
        tick();
      end
      lat_en = 1'b1; tick(); lat_en = 1'b0;
      check_all(d == 0 ? "fwd R2 R7" : "rev R3 R7");
    end

    // R6: random le/blank/direction each cycle, shift unaffected
    for (int c = 0; c < 600; c++) begin
      logic [31:0] r;
      r = $urandom(seed); seed = seed + 7;
      dir_fwd = r[0]; lat_en = r[1]; blank_n = r[2] | r[3];
      a_in = r[5:4]; b_in = r[7:6];
      tick();
      check_all("random R6 R8");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule